// File: doc/BRIEF.md
# SD Host Command Issue Gate

This block sits between the host's register-write port and the SD command engine. It holds the 32-bit command argument and the transfer-mode word. When the mode word is written, the block either launches the command, drops the write without a trace, or stores it with the transfer-control bits frozen. The decision rests on the command-line and data-line busy flags, the programmed block size and block count, the level of the write-protect switch, and whether a data transfer is running.

After it accepts a command that carries data, the block watches for the card's response. It counts card-clock ticks, and if the response is missing after 64 ticks it emits a one-cycle abort pulse for the data path. It also raises a sticky time-out flag that software clears. CRC generation, serialisation, DMA and the data path itself live elsewhere.

Top module: `sd_cmd_issue_gate`

## Requirements
- R1: A stored argument appears in `cmd_frame` bits 39:8, one cycle after `arg_wr_en`. The frame also carries:
  - bits 47:46 = 2'b01;
  - bits 45:40 = mode bits 13:8, the command index;
  - bits 7:0 = 8'h01.
- R2: A write to the argument while `dat_busy` is 1 leaves the stored argument unchanged.
- R3: While `cmd_busy` is 1, a mode write leaves `xfer_mode` unchanged and produces no `cmd_start`.
- R4: While `dat_busy` is 1, a mode write whose data-present bit (bit 6) is 1 is dropped. A write with bit 6 at 0 is still accepted.
- R5: A data command (bit 6 = 1) is dropped while `blk_size` is 0.
- R6: A data command is dropped when the multi-block bit (bit 5) and the count-enable bit (bit 1) are both 1 and `blk_cnt` is 0. If either bit is 0, a zero count does not block it.
- R7: A data command with the direction bit (bit 4) at 0, meaning card write, is dropped unless `wp_level` is 1. With bit 4 at 1 (read), `wp_level` has no effect.
- R8: An accepted mode write updates `xfer_mode` and pulses `cmd_start` high, both in the cycle after the write. A dropped write changes neither.
- R9: While `data_active` is 1, a mode write keeps the old values of the protected bits and updates every other bit. The protected bits are:
  - 0 (DMA enable);
  - 1 (count enable);
  - 2 (auto stop command);
  - 4 (direction);
  - 5 (multi-block);
  - 6 (data present).

  The accept rules are applied to the merged value.
- R10: `single_blk` is 1 whenever `xfer_mode` bit 5 is 0, whatever bit 1 and `blk_cnt` hold.
- R11: After an accepted data command, the timer counts only cycles with `card_tick` = 1.
  - On the 64th such tick without `resp_rcvd`, `resp_abort` pulses for one cycle in the following cycle.
  - A `resp_rcvd` in any earlier cycle, or in the cycle of the 64th tick, cancels the time-out.
- R12: `resp_timeout` rises together with the abort and stays set until `to_clr`. A new time-out arriving in the same cycle as `to_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr_en | input | 1 | Argument write strobe |
| arg_wr_data | input | ARG_W | Argument write data |
| xfer_wr_en | input | 1 | Mode-word write strobe |
| xfer_wr_data | input | MODE_W | Mode-word write data |
| cmd_busy | input | 1 | Command line busy |
| dat_busy | input | 1 | Data line busy |
| data_active | input | 1 | A data transfer is in progress |
| blk_size | input | BSZ_W | Programmed block size |
| blk_cnt | input | BCNT_W | Programmed block count |
| wp_level | input | 1 | Write-protect switch level, 1 = writable |
| card_tick | input | 1 | Card clock enable tick |
| resp_rcvd | input | 1 | Response received strobe |
| to_clr | input | 1 | Clear the time-out flag |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_frame | output | ARG_W+16 | Command frame fields (CRC bits zero) |
| xfer_mode | output | MODE_W | Latched transfer mode |
| single_blk | output | 1 | Single-block transfer indication |
| resp_abort | output | 1 | One-cycle data-transfer abort |
| resp_timeout | output | 1 | Sticky response time-out flag |

## Verification
Two pairs of events can fall on the same clock edge.
- **Response against time-out.** A response can arrive exactly on the 64th card tick. The bench drives `resp_rcvd` and `card_tick` together in that cycle and expects neither an abort nor a flag.
- **Software clear against a fresh time-out.** A clear can coincide with a new time-out. The bench raises `to_clr` in the 64th-tick cycle of a second timed command and expects the flag to remain set.

A behavioural model updated on every edge judges both cases, along with every other cycle of the run.

// File: rtl/sd_gate_pkg.sv
package sd_gate_pkg;
  // Bit positions inside the transfer-mode word.
  localparam int B_DMA    = 0;
  localparam int B_CNTEN  = 1;
  localparam int B_ASTOP  = 2;
  localparam int B_READ   = 4;
  localparam int B_MULTI  = 5;
  localparam int B_DATA   = 6;
  localparam int IDX_LO   = 8;
  localparam int IDX_W    = 6;
  // Bits frozen while a data transfer runs.
  localparam logic [15:0] PROT_MASK = 16'h0077;
endpackage

// File: rtl/sd_xfer_rules.sv
module sd_xfer_rules
  import sd_gate_pkg::*;
#(
  parameter int MODE_W = 16,
  parameter int BSZ_W  = 12,
  parameter int BCNT_W = 16
) (
  input  logic [MODE_W-1:0] wr_data,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              data_active,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [BCNT_W-1:0] blk_cnt,
  input  logic              wp_level,
  output logic [MODE_W-1:0] eff_mode,
  output logic              accept,
  output logic              is_data
);
  localparam logic [MODE_W-1:0] PM = MODE_W'(PROT_MASK);

  logic cnt_ok, wp_ok, data_ok;

  always_comb begin
    eff_mode = data_active ? ((wr_data & ~PM) | (cur_mode & PM)) : wr_data;
    is_data  = eff_mode[B_DATA];
    cnt_ok   = !eff_mode[B_MULTI] || !eff_mode[B_CNTEN] || (blk_cnt != '0);
    wp_ok    = eff_mode[B_READ] || wp_level;
    data_ok  = !dat_busy && (blk_size != '0) && cnt_ok && wp_ok;
    accept   = !cmd_busy && (!is_data || data_ok);
  end
endmodule

// File: rtl/sd_resp_timer.sv
module sd_resp_timer #(
  parameter int TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic resp,
  input  logic clr,
  output logic abort,
  output logic timeout
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      abort   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (clr) timeout <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (resp) begin
          armed <= 1'b0;
        end else if (tick) begin
          if (cnt == LAST) begin
            armed   <= 1'b0;
            abort   <= 1'b1;
            timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sd_cmd_issue_gate.sv
module sd_cmd_issue_gate
  import sd_gate_pkg::*;
#(
  parameter int ARG_W  = 32,
  parameter int MODE_W = 16,
  parameter int BSZ_W  = 12,
  parameter int BCNT_W = 16,
  parameter int TO_TICKS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arg_wr_en,
  input  logic [ARG_W-1:0]    arg_wr_data,
  input  logic                xfer_wr_en,
  input  logic [MODE_W-1:0]   xfer_wr_data,
  input  logic                cmd_busy,
  input  logic                dat_busy,
  input  logic                data_active,
  input  logic [BSZ_W-1:0]    blk_size,
  input  logic [BCNT_W-1:0]   blk_cnt,
  input  logic                wp_level,
  input  logic                card_tick,
  input  logic                resp_rcvd,
  input  logic                to_clr,
  output logic                cmd_start,
  output logic [ARG_W+15:0]   cmd_frame,
  output logic [MODE_W-1:0]   xfer_mode,
  output logic                single_blk,
  output logic                resp_abort,
  output logic                resp_timeout
);
  logic [ARG_W-1:0]  arg_q;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] eff_mode;
  logic              ok, is_data, take, arm;

  sd_xfer_rules #(.MODE_W(MODE_W), .BSZ_W(BSZ_W), .BCNT_W(BCNT_W)) u_rules (
    .wr_data     (xfer_wr_data),
    .cur_mode    (mode_q),
    .data_active (data_active),
    .cmd_busy    (cmd_busy),
    .dat_busy    (dat_busy),
    .blk_size    (blk_size),
    .blk_cnt     (blk_cnt),
    .wp_level    (wp_level),
    .eff_mode    (eff_mode),
    .accept      (ok),
    .is_data     (is_data)
  );

  assign take = xfer_wr_en && ok;
  assign arm  = take && is_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q     <= '0;
      mode_q    <= '0;
      cmd_start <= 1'b0;
    end else begin
      cmd_start <= take;
      if (take) mode_q <= eff_mode;
      if (arg_wr_en && !dat_busy) arg_q <= arg_wr_data;
    end
  end

  sd_resp_timer #(.TICKS(TO_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .tick    (card_tick),
    .resp    (resp_rcvd),
    .clr     (to_clr),
    .abort   (resp_abort),
    .timeout (resp_timeout)
  );

  assign xfer_mode  = mode_q;
  assign single_blk = ~mode_q[B_MULTI];
  assign cmd_frame  = {2'b01, mode_q[IDX_LO +: IDX_W], arg_q, 7'd0, 1'b1};
endmodule

// File: rtl/sd_cmd_issue_gate_chk.sv
module sd_cmd_issue_gate_chk
  import sd_gate_pkg::*;
#(
  parameter int ARG_W  = 32,
  parameter int MODE_W = 16,
  parameter int BSZ_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              arg_wr_en,
  input logic              xfer_wr_en,
  input logic [MODE_W-1:0] xfer_wr_data,
  input logic              cmd_busy,
  input logic              dat_busy,
  input logic              data_active,
  input logic [BSZ_W-1:0]  blk_size,
  input logic              to_clr,
  input logic              cmd_start,
  input logic [ARG_W+15:0] cmd_frame,
  input logic [MODE_W-1:0] xfer_mode,
  input logic              resp_abort,
  input logic              resp_timeout
);
  localparam logic [MODE_W-1:0] PM = MODE_W'(PROT_MASK);

  a_r2_arg_locked: assert property (@(posedge clk) disable iff (rst)
    (arg_wr_en && dat_busy) |=> $stable(cmd_frame[ARG_W+7:8]));

  a_r3_cmd_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (xfer_wr_en && cmd_busy) |=> (!cmd_start && $stable(xfer_mode)));

  a_r4_data_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (xfer_wr_en && dat_busy && xfer_wr_data[B_DATA] && !data_active) |=> !cmd_start);

  a_r5_zero_size_drop: assert property (@(posedge clk) disable iff (rst)
    (xfer_wr_en && xfer_wr_data[B_DATA] && !data_active && blk_size == '0) |=> !cmd_start);

  a_r9_frozen_bits: assert property (@(posedge clk) disable iff (rst)
    (xfer_wr_en && data_active) |=> ((xfer_mode & PM) == ($past(xfer_mode) & PM)));

  a_r11_abort_single: assert property (@(posedge clk) disable iff (rst)
    resp_abort |=> !resp_abort);

  a_r12_flag_with_abort: assert property (@(posedge clk) disable iff (rst)
    resp_abort |-> resp_timeout);

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (resp_timeout && !to_clr) |=> resp_timeout);
endmodule

bind sd_cmd_issue_gate sd_cmd_issue_gate_chk #(
  .ARG_W(ARG_W), .MODE_W(MODE_W), .BSZ_W(BSZ_W)
) u_chk (
  .clk(clk), .rst(rst), .arg_wr_en(arg_wr_en), .xfer_wr_en(xfer_wr_en),
  .xfer_wr_data(xfer_wr_data), .cmd_busy(cmd_busy), .dat_busy(dat_busy),
  .data_active(data_active), .blk_size(blk_size), .to_clr(to_clr),
  .cmd_start(cmd_start), .cmd_frame(cmd_frame), .xfer_mode(xfer_mode),
  .resp_abort(resp_abort), .resp_timeout(resp_timeout)
);

// File: tb/tb_sd_cmd_issue_gate.sv
`timescale 1ns/1ps
module tb_sd_cmd_issue_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arg_wr_en = 1'b0;
  logic [31:0] arg_wr_data = '0;
  logic        xfer_wr_en = 1'b0;
  logic [15:0] xfer_wr_data = '0;
  logic        cmd_busy = 1'b0, dat_busy = 1'b0, data_active = 1'b0;
  logic [11:0] blk_size = 12'd512;
  logic [15:0] blk_cnt = 16'd4;
  logic        wp_level = 1'b1, card_tick = 1'b0, resp_rcvd = 1'b0, to_clr = 1'b0;
  logic        cmd_start, single_blk, resp_abort, resp_timeout;
  logic [47:0] cmd_frame;
  logic [15:0] xfer_mode;

  always #4 clk = ~clk;

  sd_cmd_issue_gate dut (
    .clk(clk), .rst(rst), .arg_wr_en(arg_wr_en), .arg_wr_data(arg_wr_data),
    .xfer_wr_en(xfer_wr_en), .xfer_wr_data(xfer_wr_data), .cmd_busy(cmd_busy),
    .dat_busy(dat_busy), .data_active(data_active), .blk_size(blk_size),
    .blk_cnt(blk_cnt), .wp_level(wp_level), .card_tick(card_tick),
    .resp_rcvd(resp_rcvd), .to_clr(to_clr), .cmd_start(cmd_start),
    .cmd_frame(cmd_frame), .xfer_mode(xfer_mode), .single_blk(single_blk),
    .resp_abort(resp_abort), .resp_timeout(resp_timeout)
  );

  // Behavioural reference model
  logic [31:0] m_arg;
  logic [15:0] m_mode;
  logic        m_start, m_abort, m_to, m_armed;
  integer      m_ticks;
  integer      n_cmp = 0, n_bad = 0;
  string       cur_req = "R8";
  bit          done = 0;

  always @(posedge clk) begin : model
    logic [15:0] w;
    logic        ok, arm;
    if (rst) begin
      m_arg = 0; m_mode = 0; m_start = 0; m_abort = 0; m_to = 0;
      m_armed = 0; m_ticks = 0;
    end else begin
      m_start = 0; m_abort = 0; arm = 0;
      w = xfer_wr_data;
      if (data_active) begin
        // R9: protected positions 0,1,2,4,5,6 take the old value
        foreach (w[i]) if (i == 0 || i == 1 || i == 2 || i == 4 || i == 5 || i == 6) w[i] = m_mode[i];
      end
      ok = !cmd_busy;
      if (w[6]) begin
        if (dat_busy) ok = 0;
        if (blk_size == 0) ok = 0;
        if (w[5] && w[1] && blk_cnt == 0) ok = 0;
        if (!w[4] && !wp_level) ok = 0;
      end
      if (xfer_wr_en && ok) begin
        m_mode = w; m_start = 1; arm = w[6];
      end
      if (arg_wr_en && !dat_busy) m_arg = arg_wr_data;
      if (to_clr) m_to = 0;
      if (arm) begin m_armed = 1; m_ticks = 0; end
      else if (m_armed) begin
        if (resp_rcvd) m_armed = 0;
        else if (card_tick) begin
          m_ticks = m_ticks + 1;
          if (m_ticks == 64) begin m_armed = 0; m_abort = 1; m_to = 1; end
        end
      end
    end
  end

  task automatic chk(input string what, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("cmd_start", cur_req, 64'(cmd_start), 64'(m_start));
    chk("frame", "R1", 64'(cmd_frame), 64'({2'b01, m_mode[13:8], m_arg, 8'h01}));
    chk("xfer_mode", cur_req, 64'(xfer_mode), 64'(m_mode));
    chk("single_blk", "R10", 64'(single_blk), 64'(!m_mode[5]));
    chk("resp_abort", "R11", 64'(resp_abort), 64'(m_abort));
    chk("resp_timeout", "R12", 64'(resp_timeout), 64'(m_to));
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic xw(input logic [15:0] v);
    xfer_wr_en = 1; xfer_wr_data = v; @(negedge clk); xfer_wr_en = 0; @(negedge clk);
  endtask

  task automatic aw(input logic [31:0] v);
    arg_wr_en = 1; arg_wr_data = v; @(negedge clk); arg_wr_en = 0; @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      card_tick = 1; @(negedge clk); card_tick = 0; @(negedge clk);
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    idle(1);
    // R1 / R8: plain command with argument
    cur_req = "R8"; aw(32'hDEAD_BEEF); xw(16'h1100); idle(2);
    // R2: argument locked while data line busy
    cur_req = "R2"; dat_busy = 1; aw(32'h1234_5678); dat_busy = 0; aw(32'h0BAD_F00D);
    // R3: everything dropped while command line busy
    cur_req = "R3"; cmd_busy = 1; xw(16'h2300); xw(16'h0550); cmd_busy = 0;
    // R4: data command dropped on data busy, plain command goes
    cur_req = "R4"; dat_busy = 1; xw(16'h0A50); xw(16'h0C00); dat_busy = 0;
    // R5: zero block size
    cur_req = "R5"; blk_size = 0; xw(16'h1150); xw(16'h0D00); blk_size = 12'd512;
    // R6: block count rules
    cur_req = "R6"; blk_cnt = 0; wp_level = 1;
    xw(16'h1272); xw(16'h1370); xw(16'h1452); blk_cnt = 5; xw(16'h1572);
    resp_rcvd = 1; idle(1); resp_rcvd = 0;
    // R7: write protect gates card-write data commands only
    cur_req = "R7"; wp_level = 0; xw(16'h1840); xw(16'h1950); wp_level = 1; xw(16'h1A40);
    resp_rcvd = 1; idle(1); resp_rcvd = 0;
    // R9: frozen bits during an active transfer
    cur_req = "R9"; data_active = 1; xw(16'h2B00); xw(16'h2C37); data_active = 0;
    resp_rcvd = 1; idle(1); resp_rcvd = 0;
    // R10: single block regardless of count enable
    cur_req = "R10"; blk_cnt = 0; xw(16'h0D02); blk_cnt = 7; xw(16'h0E02);
    // R11: full time-out
    cur_req = "R11"; xw(16'h1150); ticks(63); idle(3); ticks(1); idle(3);
    // R12: clear then sticky
    cur_req = "R12"; to_clr = 1; idle(1); to_clr = 0; idle(2);
    // R11: response part way through cancels
    cur_req = "R11"; xw(16'h1150); ticks(30); resp_rcvd = 1; idle(1); resp_rcvd = 0; ticks(50);
    // R11: response on the 64th tick wins
    xw(16'h1150); ticks(63); card_tick = 1; resp_rcvd = 1; @(negedge clk);
    card_tick = 0; resp_rcvd = 0; idle(3);
    // R12: new time-out coincides with clear; flag must stay
    cur_req = "R12"; xw(16'h1150); ticks(30); to_clr = 1; idle(1); to_clr = 0;
    xw(16'h1150); ticks(63); card_tick = 1; to_clr = 1; @(negedge clk);
    card_tick = 0; to_clr = 0; idle(4);
    // reset returns to idle state
    cur_req = "R8"; rst = 1; idle(2); rst = 0; idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule